// File: doc/BRIEF.md
# Stack Call and Return Sequencer

This block carries out the stack-related steps of a small 16-bit processor: pushing a register, popping into a register, absolute and relative subroutine calls, returns, returns from an interrupt handler, and software interrupts. It works on a word-addressed memory. It keeps its own stack pointer, which moves toward lower addresses. It also keeps a program counter and a four-bit flag register, and it reports all three after every operation. Instruction fetch and decode stay outside. The caller pulses `start` with an operation code, a target value, the word to push, the address of the instruction after the current one, and the current flags. It then waits for the one-cycle `done` pulse.

The stack is always ready for insertion. A store goes to the word the pointer names, and then the pointer moves down. A retrieval first moves the pointer up, and then reads. A call or interrupt leaves a two-word frame. The return address goes at the higher address and the flags at the word below it. A return reads the frame back in the opposite order. Memory reads are synchronous: read data comes back on the cycle after the read strobe.

Operation codes on `opCode`: 0 push, 1 pop, 2 absolute call, 3 relative call, 4 return, 5 return from interrupt, 6 software interrupt. Code 7 is not an operation.

Top module: `stack_seq`

## Requirements
- R1: After reset, `spOut` is the stack pointer reset value (default 16'hFFFF), `pcOut`, `flagsOut`, `popData` are zero, `inService` and `done` are low, and neither memory strobe is active.
- R2: Push (code 0) writes `pushData` to memory at the current SP in its first execute cycle, then lowers SP by one. `pcOut` and `flagsOut` become `retPc` and `flagsIn` as presented with `start`.
- R3: Pop (code 1) raises SP by one, then reads memory at the new SP. The word read appears on `popData`.
- R4: Absolute call (code 2) writes `retPc` at SP, then the zero-extended flags at SP-1. It leaves SP two lower and then loads `pcOut` with `target`.
- R5: Relative call (code 3) builds the same frame as R4 and loads `pcOut` with `retPc + target` modulo 2^16.
- R6: Return (code 4) restores the flags from the low four bits of memory at SP+1 and the PC from memory at SP+2, and leaves SP two higher.
- R7: A software interrupt sets `inService`. Return from interrupt (code 5) acts as R6 and also clears `inService`.
- R8: Software interrupt (code 6) builds the R4 frame and then loads `pcOut` from the memory word at the address `target[7:0]` (upper address bits zero). Bits 15:8 of `target` are ignored.
- R9: SP arithmetic wraps modulo 2^16 in both directions without any other effect.
- R10: A `start` raised while an operation is in progress is ignored.
- R11: A `start` with code 7 is ignored: no memory access, no `done`, and SP, PC and flags hold.
- R12: `memRd` and `memWr` are never active together, and neither is active while the block is idle.
- R13: `done` is a single-cycle pulse in the 3rd execute cycle of push and pop, and in the 8th execute cycle of the calls, returns and the software interrupt. The results are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| opCode | input | 3 | Operation code |
| target | input | 16 | Absolute address, relative offset or vector (low byte) |
| pushData | input | 16 | Word to push |
| retPc | input | 16 | Address of the following instruction |
| flagsIn | input | 4 | Current flag register |
| memRdata | input | 16 | Memory read data, valid the cycle after `memRd` |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Memory write data |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| spOut | output | 16 | Stack pointer |
| pcOut | output | 16 | Program counter |
| flagsOut | output | 4 | Flag register |
| popData | output | 16 | Word retrieved by the last pop |
| inService | output | 1 | Interrupt-in-service indication |
| done | output | 1 | Completion pulse |

## Verification
The edge that accepts `start` counts as the edge before execute cycle 1. `done` must be high in execute cycle 3 (push, pop) or execute cycle 8 (the others). SP, PC, flags, `popData`, `inService` and the memory image are due one cycle after `done`. The bench drives inputs on falling edges and counts falling edges from the accepting edge until `done`. It compares that count to 3 or 8, then samples every result on the next falling edge. Memory writes are checked by comparing the whole bench memory with a shadow image that the bench updates from the requirements, in frame order. The ignore cases are checked by watching `done` and SP for ten further cycles.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_CALLR = 3'd3,
    OP_RET   = 3'd4,
    OP_RETI  = 3'd5,
    OP_SWI   = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  localparam int EXEC_SHORT = 3;
  localparam int EXEC_LONG  = 8;

  // strobes from control to datapath, one per register action
  typedef struct packed {
    logic capture;
    logic wrPc;
    logic wrFlags;
    logic wrData;
    logic rdStack;
    logic rdVec;
    logic spInc;
    logic spDec;
    logic pcAbs;
    logic pcRel;
    logic pcMem;
    logic flagsMem;
    logic popLoad;
    logic svcSet;
    logic svcClr;
  } strobe_t;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opCode,
  output strobe_t    st,
  output logic       done
);

  localparam int SW = $clog2(EXEC_LONG);

  logic          busyQ;
  op_e           opQ;
  logic [SW-1:0] stepQ;
  logic [SW-1:0] lastStep;
  logic          accept;

  assign accept   = start && !busyQ && (opCode != OP_NONE);
  assign lastStep = (opQ == OP_PUSH || opQ == OP_POP) ? SW'(EXEC_SHORT - 1)
                                                      : SW'(EXEC_LONG - 1);
  assign done     = busyQ && (stepQ == lastStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      opQ   <= OP_NONE;
      stepQ <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      opQ   <= op_e'(opCode);
      stepQ <= '0;
    end else if (busyQ) begin
      if (done) busyQ <= 1'b0;
      else      stepQ <= stepQ + 1'b1;
    end
  end

  always_comb begin
    st         = '0;
    st.capture = accept;
    if (busyQ) begin
      unique case (opQ)
        OP_PUSH: begin
          case (int'(stepQ))
            0: st.wrData = 1'b1;
            1: st.spDec  = 1'b1;
            default: ;
          endcase
        end
        OP_POP: begin
          case (int'(stepQ))
            0: st.spInc   = 1'b1;
            1: st.rdStack = 1'b1;
            2: st.popLoad = 1'b1;
            default: ;
          endcase
        end
        OP_CALL, OP_CALLR, OP_SWI: begin
          case (int'(stepQ))
            0: st.wrPc    = 1'b1;
            1: st.spDec   = 1'b1;
            2: st.wrFlags = 1'b1;
            3: st.spDec   = 1'b1;
            4: begin
              st.pcAbs = (opQ == OP_CALL);
              st.pcRel = (opQ == OP_CALLR);
              st.rdVec = (opQ == OP_SWI);
            end
            5: begin
              st.pcMem  = (opQ == OP_SWI);
              st.svcSet = (opQ == OP_SWI);
            end
            default: ;
          endcase
        end
        OP_RET, OP_RETI: begin
          case (int'(stepQ))
            0: st.spInc   = 1'b1;
            1: st.rdStack = 1'b1;
            2: begin
              st.flagsMem = 1'b1;
              st.spInc    = 1'b1;
            end
            3: st.rdStack = 1'b1;
            4: st.pcMem   = 1'b1;
            7: st.svcClr  = (opQ == OP_RETI);
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          FW       = 4,
  parameter int          VW       = 8,
  parameter logic [DW-1:0] SP_RESET = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] pushData,
  input  logic [DW-1:0] retPc,
  input  logic [FW-1:0] flagsIn,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] pcOut,
  output logic [FW-1:0] flagsOut,
  output logic [DW-1:0] popData,
  output logic          inService
);

  logic [DW-1:0] spQ, pcQ, tgtQ, dataQ, popQ;
  logic [FW-1:0] flagsQ;
  logic          svcQ;

  assign memRd = st.rdStack | st.rdVec;
  assign memWr = st.wrPc | st.wrFlags | st.wrData;

  assign memAddr  = st.rdVec ? {{(DW-VW){1'b0}}, tgtQ[VW-1:0]} : spQ;
  assign memWdata = st.wrPc    ? pcQ :
                    st.wrFlags ? {{(DW-FW){1'b0}}, flagsQ} : dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ    <= SP_RESET;
      pcQ    <= '0;
      flagsQ <= '0;
      tgtQ   <= '0;
      dataQ  <= '0;
      popQ   <= '0;
      svcQ   <= 1'b0;
    end else begin
      if (st.capture) begin
        pcQ    <= retPc;
        flagsQ <= flagsIn;
        tgtQ   <= target;
        dataQ  <= pushData;
      end
      if (st.spInc)    spQ    <= spQ + 1'b1;
      if (st.spDec)    spQ    <= spQ - 1'b1;
      if (st.pcAbs)    pcQ    <= tgtQ;
      if (st.pcRel)    pcQ    <= pcQ + tgtQ;
      if (st.pcMem)    pcQ    <= memRdata;
      if (st.flagsMem) flagsQ <= memRdata[FW-1:0];
      if (st.popLoad)  popQ   <= memRdata;
      if (st.svcSet)   svcQ   <= 1'b1;
      if (st.svcClr)   svcQ   <= 1'b0;
    end
  end

  assign spOut     = spQ;
  assign pcOut     = pcQ;
  assign flagsOut  = flagsQ;
  assign popData   = popQ;
  assign inService = svcQ;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            FW       = 4,
  parameter int            VW       = 8,
  parameter logic [DW-1:0] SP_RESET = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    opCode,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] pushData,
  input  logic [DW-1:0] retPc,
  input  logic [FW-1:0] flagsIn,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] pcOut,
  output logic [FW-1:0] flagsOut,
  output logic [DW-1:0] popData,
  output logic          inService,
  output logic          done
);

  strobe_t st;

  stack_seq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opCode (opCode),
    .st     (st),
    .done   (done)
  );

  stack_seq_dp #(.DW(DW), .FW(FW), .VW(VW), .SP_RESET(SP_RESET)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .target    (target),
    .pushData  (pushData),
    .retPc     (retPc),
    .flagsIn   (flagsIn),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRd     (memRd),
    .memWr     (memWr),
    .spOut     (spOut),
    .pcOut     (pcOut),
    .flagsOut  (flagsOut),
    .popData   (popData),
    .inService (inService)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [2:0]    opCode,
  input logic [DW-1:0] pushData,
  input logic [DW-1:0] spOut,
  input logic [DW-1:0] pcOut,
  input logic [DW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memRd,
  input logic          memWr,
  input logic          done
);

  // independent occupancy model: set on an accepted request, cleared by done
  logic busyM;
  logic takeReq;

  assign takeReq = start && !busyM && (opCode != 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busyM <= 1'b0;
    else if (takeReq) busyM <= 1'b1;
    else if (done)    busyM <= 1'b0;
  end

  p_rdwr_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busyM |-> !(memRd || memWr));

  p_push_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && opCode == 3'd0) |=>
      (memWr && memAddr == $past(spOut) && memWdata == $past(pushData)));

  p_ret_first_inc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && opCode == 3'd4) |=> ##1 (spOut == DW'($past(spOut, 2) + 1'b1)));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busyM && !takeReq) |=> ($stable(spOut) && $stable(pcOut)));

endmodule

bind stack_seq stack_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/stack_seq_tb.sv
module stack_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] target = '0, pushData = '0, retPc = '0;
  logic [3:0]  flagsIn = '0;
  logic [15:0] memRdata = '0;
  logic [15:0] memAddr, memWdata, spOut, pcOut, popData;
  logic        memRd, memWr, inService, done;
  logic [3:0]  flagsOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  stack_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .target(target),
    .pushData(pushData), .retPc(retPc), .flagsIn(flagsIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memRd(memRd), .memWr(memWr),
    .spOut(spOut), .pcOut(pcOut), .flagsOut(flagsOut), .popData(popData),
    .inService(inService), .done(done)
  );

  // memory model: 256 words, aliased on the low address byte, registered read
  logic [15:0] mem [256];
  logic [15:0] expMem [256];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 37 + 5);
    end else begin
      if (memWr) mem[memAddr[7:0]] <= memWdata;
      if (memRd) memRdata <= mem[memAddr[7:0]];
    end
  end

  // reference state
  logic [15:0] eSp = 16'hFFFF, ePc = '0, ePop = '0;
  logic [3:0]  eFl = '0;
  logic        eSvc = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic modelOp(input logic [2:0] op, input logic [15:0] tgt, pd, rpc,
                         input logic [3:0] fl);
    ePc = rpc;
    eFl = fl;
    case (op)
      3'd0: begin
        expMem[eSp[7:0]] = pd;
        eSp = eSp - 16'd1;
      end
      3'd1: begin
        eSp = eSp + 16'd1;
        ePop = expMem[eSp[7:0]];
      end
      3'd2, 3'd3, 3'd6: begin
        expMem[eSp[7:0]] = rpc;
        eSp = eSp - 16'd1;
        expMem[eSp[7:0]] = {12'd0, fl};
        eSp = eSp - 16'd1;
        if (op == 3'd2) ePc = tgt;
        else if (op == 3'd3) ePc = rpc + tgt;
        else begin
          ePc = expMem[tgt[7:0]];
          eSvc = 1'b1;
        end
      end
      default: begin
        eSp = eSp + 16'd1;
        eFl = expMem[eSp[7:0]][3:0];
        eSp = eSp + 16'd1;
        ePc = expMem[eSp[7:0]];
        if (op == 3'd5) eSvc = 1'b0;
      end
    endcase
  endtask

  task automatic runOp(input logic [2:0] op, input logic [15:0] tgt, pd, rpc,
                       input logic [3:0] fl, input bit glitch);
    int cyc;
    int want;
    bit seen;
    bit memOk;
    string tag;
    tag = tagOf(op);
    want = (op <= 3'd1) ? 3 : 8;
    modelOp(op, tgt, pd, rpc, fl);
    @(negedge clk);
    start = 1'b1; opCode = op; target = tgt; pushData = pd; retPc = rpc; flagsIn = fl;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    seen = 1'b0;
    while (!seen && cyc <= 12) begin
      // R10: a second request raised mid-operation must be ignored
      if (glitch && cyc == 2) begin start = 1'b1; opCode = 3'd1; end
      else start = 1'b0;
      if (done) seen = 1'b1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    chk("R13 done cycle", 32'(cyc), 32'(want));
    @(negedge clk);
    chk({tag, " sp"}, {16'd0, spOut}, {16'd0, eSp});
    chk({tag, " pc"}, {16'd0, pcOut}, {16'd0, ePc});
    chk({tag, " flags"}, {28'd0, flagsOut}, {28'd0, eFl});
    chk({tag, " popData"}, {16'd0, popData}, {16'd0, ePop});
    chk("R7 inService", {31'd0, inService}, {31'd0, eSvc});
    chk("R13 done low after", {31'd0, done}, 32'd0);
    memOk = 1'b1;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) memOk = 1'b0;
    chk({tag, " memory image"}, {31'd0, memOk}, 32'd1);
    if (glitch) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        chk("R10 no second done", {31'd0, done}, 32'd0);
      end
      chk("R10 sp unchanged", {16'd0, spOut}, {16'd0, eSp});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    bit sawAccess;
    logic [2:0] rop;
    for (int i = 0; i < 256; i++) expMem[i] = 16'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", {16'd0, spOut}, 32'h0000FFFF);
    chk("R1 pc", {16'd0, pcOut}, 32'd0);
    chk("R1 flags", {28'd0, flagsOut}, 32'd0);
    chk("R1 popData", {16'd0, popData}, 32'd0);
    chk("R1 inService", {31'd0, inService}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 strobes", {30'd0, memRd, memWr}, 32'd0);

    // R9 wrap upward on pop from FFFF, then downward on push from 0000
    runOp(3'd1, 16'h0, 16'h0, 16'h0100, 4'h0, 1'b0);
    chk("R9 sp wrapped up", {16'd0, spOut}, 32'h00000000);
    runOp(3'd0, 16'h0, 16'hBEEF, 16'h0102, 4'h3, 1'b0);
    chk("R9 sp wrapped down", {16'd0, spOut}, 32'h0000FFFF);

    // R2 push, R3 pop round trip
    runOp(3'd0, 16'h0, 16'h1234, 16'h0200, 4'h5, 1'b0);
    runOp(3'd1, 16'h0, 16'h0, 16'h0201, 4'h6, 1'b0);
    chk("R3 pop returns pushed word", {16'd0, popData}, 32'h00001234);

    // R4 absolute call, R6 return
    runOp(3'd2, 16'h4000, 16'h0, 16'h0302, 4'hA, 1'b0);
    runOp(3'd4, 16'h0, 16'h0, 16'h4001, 4'h0, 1'b0);
    chk("R6 pc back", {16'd0, pcOut}, 32'h00000302);
    chk("R6 flags back", {28'd0, flagsOut}, 32'h0000000A);

    // R5 relative call with PC wrap
    runOp(3'd3, 16'h0020, 16'h0, 16'hFFF0, 4'h1, 1'b0);
    chk("R5 pc wrapped", {16'd0, pcOut}, 32'h00000010);
    runOp(3'd4, 16'h0, 16'h0, 16'h0011, 4'h0, 1'b0);

    // R8 software interrupt, upper target bits ignored; R7 return from it
    runOp(3'd6, 16'hAB05, 16'h0, 16'h0500, 4'h9, 1'b0);
    chk("R8 pc from vector", {16'd0, pcOut}, 32'(16'(5 * 37 + 5)));
    chk("R7 inService set", {31'd0, inService}, 32'd1);
    runOp(3'd5, 16'h0, 16'h0, 16'h0700, 4'h0, 1'b0);
    chk("R7 inService cleared", {31'd0, inService}, 32'd0);
    chk("R7 pc back", {16'd0, pcOut}, 32'h00000500);

    // R10 request during a long operation
    runOp(3'd2, 16'h2222, 16'h0, 16'h0800, 4'h4, 1'b1);

    // R11 code 7 ignored
    @(negedge clk);
    start = 1'b1; opCode = 3'd7;
    @(negedge clk);
    start = 1'b0;
    sawAccess = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (done || memRd || memWr) sawAccess = 1'b1;
      @(negedge clk);
    end
    chk("R11 no activity", {31'd0, sawAccess}, 32'd0);
    chk("R11 sp hold", {16'd0, spOut}, {16'd0, eSp});
    chk("R11 pc hold", {16'd0, pcOut}, {16'd0, ePc});

    // constrained random mix
    seed = $urandom(32'd20240611);
    for (int n = 0; n < 300; n++) begin
      rop = 3'($urandom % 7);
      runOp(rop, 16'($urandom), 16'($urandom), 16'($urandom), 4'($urandom),
            ($urandom % 16) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule